// File: doc/BRIEF.md
# Debounced Input Interrupt Bank

This block watches a group of input-only pins and turns qualified level changes into interrupt requests. Each pin passes through a clock-domain synchronizer and then a filter of its own. The filter accepts a new level only after the pin has held it for a programmed number of millisecond ticks. The block does not make its own time base. The `ms_tick` input supplies it as a single-cycle pulse each millisecond.

Software reaches the block over a simple word-addressed register bus. Writes take effect on a clock edge and reads are combinational. A channel reports an event when its accepted level equals its programmed polarity while the channel is armed. The event then latches a status bit and disarms the channel, so each event is reported once. Software acknowledges the event with a write-one clear and re-arms the channel when it wants the next one. A single output, `irq`, carries the OR of the enabled status bits.

Top module: `dbirq_bank`

## Requirements
- R1: A channel's accepted level takes the synchronized pin value once that value has differed from the accepted level, without changing, for N consecutive `ms_tick` pulses. N is the 12-bit limit in the channel's filter register at byte offset 0x40 + 4*n (bits [11:0]). A limit of 0 behaves as 1. The filter works the same way in both directions.
- R2: If the synchronized pin changes before N ticks have been counted, the count starts again from zero. A pulse that sees no tick, or fewer than N ticks, never reaches the accepted level.
- R3: A read of offset 0x00 returns the accepted levels in bits [7:0], one bit per channel. Only channels whose bit is 1 in the data-mask register at 0x04 show their level; every other bit reads 0.
- R4: The polarity register at 0x14 selects the active level of each channel: 1 means high is active and 0 means low is active. A channel matches when its accepted level equals its polarity bit.
- R5: The arm register is at 0x28. When an armed channel matches, its raw status bit (readable at 0x1C) sets on the next clock edge and its arm bit clears on the same edge. The status bit does not set again until software writes the arm bit back to 1. A write to the arm register takes priority over the self-clear.
- R6: Writing to offset 0x24 clears each raw status bit whose data bit is 1. Bits written as 0 leave their status unchanged.
- R7: Offset 0x20 reads the raw status ANDed with the enable register at 0x18. `irq` is high exactly when that masked value is non-zero.
- R8: Each filter register keeps only bits [11:0] and reads back zero-extended. A write to one channel's filter register leaves every other channel's register unchanged.
- R9: After reset, every register, accepted level and status bit is 0 and `irq` is low.
- R10: An accepted level changes only on a clock edge that samples `ms_tick` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| pin_in | input | 8 | Raw asynchronous input pins |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | OR of the enabled status bits |

## Verification
A pin change reaches the synchronized value two edges after it is driven. The change detector sees it on the third edge, so the first `ms_tick` that can count is the one sampled on the fourth edge or later. The bench waits four edges after each pin change before it sends any tick.

The accepted level updates on the edge that samples the Nth tick. The status bit and `irq` follow one edge later. Every check therefore reads at the second falling edge after the last tick. Register writes show on a read at the falling edge after the write edge. A re-arm shows in the status bit one edge after that, and the bench waits that extra edge before it checks.

// File: rtl/dbirq_pkg.sv
package dbirq_pkg;
   // Register byte offsets; software drivers depend on this layout.
   localparam int unsigned OFS_LEVEL    = 'h00;
   localparam int unsigned OFS_DMASK    = 'h04;
   localparam int unsigned OFS_POL      = 'h14;
   localparam int unsigned OFS_IE       = 'h18;
   localparam int unsigned OFS_RAW      = 'h1C;
   localparam int unsigned OFS_MSK      = 'h20;
   localparam int unsigned OFS_CLR      = 'h24;
   localparam int unsigned OFS_ARM      = 'h28;
   localparam int unsigned OFS_LIMIT0   = 'h40;
   localparam int unsigned LIMIT_STRIDE = 4;
endpackage

// File: rtl/dbirq_sync.sv
module dbirq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else if (STAGES == 1) chain_q <= d;
            else chain_q <= {chain_q[STAGES-2:0], d};
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/dbirq_filter.sv
module dbirq_filter #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             sync_in,
   input  logic [CNT_W-1:0] limit,
   output logic             level
);
   logic [CNT_W-1:0] cnt_q;
   logic             prev_q;
   logic             level_q;
   logic [CNT_W:0]   eff_lim;
   logic [CNT_W:0]   cnt_inc;

   assign eff_lim = (limit == '0) ? (CNT_W+1)'(1) : {1'b0, limit};
   assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         prev_q  <= 1'b0;
         level_q <= 1'b0;
      end else begin
         prev_q <= sync_in;
         if (sync_in != prev_q || sync_in == level_q) begin
            cnt_q <= '0;
         end else if (tick) begin
            if (cnt_inc >= eff_lim) begin
               level_q <= sync_in;
               cnt_q   <= '0;
            end else begin
               cnt_q <= cnt_inc[CNT_W-1:0];
            end
         end
      end
   end

   assign level = level_q;
endmodule

// File: rtl/dbirq_regs.sv
module dbirq_regs
   import dbirq_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned CNT_W  = 12,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_we,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   input  logic [NUM_CH-1:0]       level,
   output logic [DATA_W-1:0]       bus_rdata,
   output logic [NUM_CH*CNT_W-1:0] limit_flat,
   output logic [NUM_CH-1:0]       raw_q,
   output logic [NUM_CH-1:0]       arm_q,
   output logic [NUM_CH-1:0]       ie_q,
   output logic [NUM_CH-1:0]       dmask_q,
   output logic                    irq
);
   localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(OFS_LEVEL);
   localparam logic [ADDR_W-1:0] A_DMASK = ADDR_W'(OFS_DMASK);
   localparam logic [ADDR_W-1:0] A_POL   = ADDR_W'(OFS_POL);
   localparam logic [ADDR_W-1:0] A_IE    = ADDR_W'(OFS_IE);
   localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(OFS_RAW);
   localparam logic [ADDR_W-1:0] A_MSK   = ADDR_W'(OFS_MSK);
   localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
   localparam logic [ADDR_W-1:0] A_ARM   = ADDR_W'(OFS_ARM);

   logic [NUM_CH-1:0] pol_q;
   logic [NUM_CH-1:0] wch;
   logic [NUM_CH-1:0] fire;
   logic [NUM_CH-1:0] raw_next;
   logic [NUM_CH-1:0] arm_next;
   logic [NUM_CH-1:0] lim_hit;
   logic              we_clr;
   logic              we_arm;

   assign wch    = bus_wdata[NUM_CH-1:0];
   assign we_clr = bus_we && (bus_addr == A_CLR);
   assign we_arm = bus_we && (bus_addr == A_ARM);

   always_comb begin
      fire     = arm_q & ~(level ^ pol_q);
      raw_next = raw_q;
      if (we_clr) raw_next = raw_next & ~wch;
      raw_next = raw_next | fire;
      arm_next = we_arm ? wch : (arm_q & ~fire);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dmask_q <= '0;
         pol_q   <= '0;
         ie_q    <= '0;
         raw_q   <= '0;
         arm_q   <= '0;
      end else begin
         if (bus_we && bus_addr == A_DMASK) dmask_q <= wch;
         if (bus_we && bus_addr == A_POL)   pol_q   <= wch;
         if (bus_we && bus_addr == A_IE)    ie_q    <= wch;
         raw_q <= raw_next;
         arm_q <= arm_next;
      end
   end

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_lim
         localparam logic [ADDR_W-1:0] A_LIM = ADDR_W'(OFS_LIMIT0 + LIMIT_STRIDE * i);
         logic [CNT_W-1:0] lim_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lim_q <= '0;
            else if (bus_we && bus_addr == A_LIM) lim_q <= bus_wdata[CNT_W-1:0];
         end
         assign limit_flat[i*CNT_W +: CNT_W] = lim_q;
         assign lim_hit[i] = (bus_addr == A_LIM);
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         A_LEVEL: bus_rdata[NUM_CH-1:0] = level & dmask_q;
         A_DMASK: bus_rdata[NUM_CH-1:0] = dmask_q;
         A_POL:   bus_rdata[NUM_CH-1:0] = pol_q;
         A_IE:    bus_rdata[NUM_CH-1:0] = ie_q;
         A_RAW:   bus_rdata[NUM_CH-1:0] = raw_q;
         A_MSK:   bus_rdata[NUM_CH-1:0] = raw_q & ie_q;
         A_ARM:   bus_rdata[NUM_CH-1:0] = arm_q;
         default: begin
            for (int i = 0; i < NUM_CH; i++) begin
               if (lim_hit[i]) bus_rdata[CNT_W-1:0] = limit_flat[i*CNT_W +: CNT_W];
            end
         end
      endcase
   end

   assign irq = |(raw_q & ie_q);
endmodule

// File: rtl/dbirq_bank.sv
module dbirq_bank
   import dbirq_pkg::*;
#(
   parameter int unsigned NUM_CH      = 8,
   parameter int unsigned CNT_W       = 12,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ms_tick,
   input  logic [NUM_CH-1:0] pin_in,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int unsigned MAP_END = OFS_LIMIT0 + LIMIT_STRIDE * NUM_CH;

   generate
      if (NUM_CH < 1 || NUM_CH > DATA_W) begin : g_bad_ch
         $error("dbirq_bank: NUM_CH must be 1..DATA_W");
      end
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("dbirq_bank: CNT_W must be 1..DATA_W");
      end
      if (MAP_END > (1 << ADDR_W)) begin : g_bad_addr
         $error("dbirq_bank: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [NUM_CH-1:0]       sync_w;
   logic [NUM_CH-1:0]       level_w;
   logic [NUM_CH*CNT_W-1:0] limit_w;
   logic [NUM_CH-1:0]       raw_q;
   logic [NUM_CH-1:0]       arm_q;
   logic [NUM_CH-1:0]       ie_q;
   logic [NUM_CH-1:0]       dmask_q;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         dbirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pin_in[i]),
            .q     (sync_w[i])
         );
         dbirq_filter #(.CNT_W(CNT_W)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (ms_tick),
            .sync_in (sync_w[i]),
            .limit   (limit_w[i*CNT_W +: CNT_W]),
            .level   (level_w[i])
         );
      end
   endgenerate

   dbirq_regs #(
      .NUM_CH (NUM_CH),
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_we     (bus_we),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .level      (level_w),
      .bus_rdata  (bus_rdata),
      .limit_flat (limit_w),
      .raw_q      (raw_q),
      .arm_q      (arm_q),
      .ie_q       (ie_q),
      .dmask_q    (dmask_q),
      .irq        (irq)
   );
endmodule

// File: rtl/dbirq_bank_chk.sv
module dbirq_bank_chk
   import dbirq_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ms_tick,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              irq,
   input logic [NUM_CH-1:0] level_w,
   input logic [NUM_CH-1:0] raw_q,
   input logic [NUM_CH-1:0] arm_q,
   input logic [NUM_CH-1:0] dmask_q
);
   localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(OFS_LEVEL);
   localparam logic [ADDR_W-1:0] A_MSK   = ADDR_W'(OFS_MSK);
   localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
   localparam logic [ADDR_W-1:0] A_ARM   = ADDR_W'(OFS_ARM);

   AST_DATA_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_LEVEL) |-> ((bus_rdata[NUM_CH-1:0] & ~dmask_q) == '0)); // R3
   AST_RAW_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      ((raw_q & ~$past(raw_q) & ~$past(arm_q)) == '0)); // R5
   AST_ARM_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_we && bus_addr == A_ARM) |-> ((raw_q & ~$past(raw_q) & arm_q) == '0)); // R5
   AST_CLEAR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(bus_we && bus_addr == A_CLR) |->
         ((raw_q & $past(bus_wdata[NUM_CH-1:0]) & ~$past(arm_q)) == '0)); // R6
   AST_IRQ_MATCHES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == A_MSK) |-> (irq == (bus_rdata != '0))); // R7
   AST_LEVEL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (level_w != $past(level_w)) |-> $past(ms_tick)); // R10
endmodule

bind dbirq_bank dbirq_bank_chk #(
   .NUM_CH (NUM_CH),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ms_tick   (ms_tick),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq       (irq),
   .level_w   (level_w),
   .raw_q     (raw_q),
   .arm_q     (arm_q),
   .dmask_q   (dmask_q)
);

// File: tb/sim_dbirq_bank.sv
module sim_dbirq_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ms_tick = 1'b0;
   logic [7:0]  pins = 8'h00;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        irq;
   int          n_chk = 0;
   int          n_bad = 0;

   always #2 clk = ~clk;

   dbirq_bank u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .ms_tick   (ms_tick),
      .pin_in    (pins),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   typedef struct packed {
      logic [2:0]  ch;
      logic [11:0] lim;
      logic        pol;
      logic        pin;
      logic [3:0]  ticks;
      logic        exp_lvl;
      logic        exp_raw;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{3'd0, 12'd3,  1'b1, 1'b1, 4'd3,  1'b1, 1'b1},
      '{3'd1, 12'd3,  1'b1, 1'b1, 4'd2,  1'b0, 1'b0},
      '{3'd2, 12'd0,  1'b1, 1'b1, 4'd1,  1'b1, 1'b1},
      '{3'd3, 12'd5,  1'b0, 1'b1, 4'd5,  1'b1, 1'b1},
      '{3'd4, 12'd4,  1'b1, 1'b0, 4'd6,  1'b0, 1'b0},
      '{3'd7, 12'd1,  1'b1, 1'b1, 4'd0,  1'b0, 1'b0},
      '{3'd5, 12'd2,  1'b0, 1'b0, 4'd2,  1'b0, 1'b1},
      '{3'd6, 12'd15, 1'b1, 1'b1, 4'd15, 1'b1, 1'b1}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = 32'h0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; pins = 8'h00; ms_tick = 1'b0; bus_we = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic set_pin(input int ch, input logic v);
      @(negedge clk);
      pins[ch] = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) ms_tick = 1'b1;
         @(negedge clk) ms_tick = 1'b0;
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      #600000;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] r;

      // Reset state (R9)
      do_reset();
      rd(8'h00, r); chk("R9 level", r, 0);
      rd(8'h1C, r); chk("R9 raw", r, 0);
      rd(8'h28, r); chk("R9 arm", r, 0);
      rd(8'h40, r); chk("R9 limit", r, 0);
      chk("R9 irq", {31'h0, irq}, 0);

      // Table walk: R1 R2 R4 R5 R7
      for (int v = 0; v < 8; v++) begin
         do_reset();
         wr(8'h04, 32'hFF);
         wr(8'h18, 32'hFF);
         wr(8'h14, 32'(VECS[v].pol) << VECS[v].ch);
         wr(8'h40 + 8'(4 * VECS[v].ch), 32'(VECS[v].lim));
         wr(8'h28, 32'h1 << VECS[v].ch);
         set_pin(int'(VECS[v].ch), VECS[v].pin);
         ticks(int'(VECS[v].ticks));
         repeat (20) @(negedge clk);
         rd(8'h00, r); chk("R1/R2 level", {31'h0, r[VECS[v].ch]}, {31'h0, VECS[v].exp_lvl});
         rd(8'h1C, r); chk("R4 raw",      {31'h0, r[VECS[v].ch]}, {31'h0, VECS[v].exp_raw});
         rd(8'h28, r); chk("R5 arm",      {31'h0, r[VECS[v].ch]}, {31'h0, ~VECS[v].exp_raw});
         chk("R7 irq", {31'h0, irq}, {31'h0, VECS[v].exp_raw});
      end

      // Filter register width and isolation (R8)
      do_reset();
      wr(8'h48, 32'hFFFF_FFFF);
      rd(8'h48, r); chk("R8 width", r, 32'hFFF);
      rd(8'h4C, r); chk("R8 isolation", r, 0);

      // Single trigger, clear and re-arm (R5, R6)
      do_reset();
      wr(8'h04, 32'hFF); wr(8'h18, 32'hFF); wr(8'h14, 32'h01);
      wr(8'h40, 32'h1);  wr(8'h28, 32'h01);
      set_pin(0, 1'b1);
      ticks(1);
      rd(8'h1C, r); chk("R5 raw set", r, 32'h01);
      rd(8'h28, r); chk("R5 arm cleared", r, 0);
      wr(8'h24, 32'hFE);
      rd(8'h1C, r); chk("R6 zero bits keep", r, 32'h01);
      wr(8'h24, 32'h01);
      rd(8'h1C, r); chk("R6 clear", r, 0);
      repeat (10) @(negedge clk);
      rd(8'h1C, r); chk("R5 no refire", r, 0);
      chk("R7 irq after clear", {31'h0, irq}, 0);
      wr(8'h28, 32'h01);
      @(negedge clk);
      rd(8'h1C, r); chk("R5 rearm", r, 32'h01);

      // Enable gating (R7)
      wr(8'h18, 32'h00);
      rd(8'h20, r); chk("R7 masked off", r, 0);
      chk("R7 irq off", {31'h0, irq}, 0);
      rd(8'h1C, r); chk("R7 raw kept", r, 32'h01);
      wr(8'h18, 32'h01);
      rd(8'h20, r); chk("R7 masked on", r, 32'h01);
      chk("R7 irq on", {31'h0, irq}, 1);

      // Data mask (R3)
      wr(8'h04, 32'h00);
      rd(8'h00, r); chk("R3 masked data", r, 0);
      wr(8'h04, 32'h01);
      rd(8'h00, r); chk("R3 unmasked data", r, 32'h01);

      // Restart on glitch, then falling edge (R2, R1, R10)
      do_reset();
      wr(8'h04, 32'hFF); wr(8'h44, 32'd3);
      set_pin(1, 1'b1);
      ticks(2);
      set_pin(1, 1'b0);
      set_pin(1, 1'b1);
      ticks(2);
      rd(8'h00, r); chk("R2 restart", r, 0);
      ticks(1);
      rd(8'h00, r); chk("R1 accept", r, 32'h02);
      set_pin(1, 1'b0);
      repeat (30) @(negedge clk);
      rd(8'h00, r); chk("R10 hold without tick", r, 32'h02);
      ticks(3);
      rd(8'h00, r); chk("R1 fall", r, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule